// File: doc/BRIEF.md
# ADC Trigger and Conversion Sequencer

This block is the digital control sequencer for a successive-approximation analog-to-digital converter with several input channels. A conversion run can start in two ways. Software can pulse a start strobe. Alternatively, a selected hardware request can start the run on its rising edge. The hardware request comes from an external pin, a motor-control timer or a general-purpose timer. Both paths set the same start bit, at the same clock edge, with the same latency to sampling.

Once started, the sequencer waits for the next boundary of a divide-by-4 conversion-clock phase. This wait is the start delay, and it lasts 1 to 4 clocks. The sequencer then drives a sample-and-hold strobe for 6 clocks and a convert strobe for 16 clocks for each channel, and presents the channel index throughout. The mode decides how many channels are converted:

- **Single:** one channel.
- **Multi:** a group of channels, converted once.
- **Scan:** a group of channels, converted repeatedly.

In multi and scan mode, later channels follow at once without a start delay. A single or multi run ends with a one-cycle done pulse. A scan run goes on until software clears the start bit. The analog converter, the result registers and the interrupts sit outside this block.

Top module: `adc_seq`

## Requirements
- R1: While reset is asserted and immediately after it, the outputs are all zero: `start_bit`, `busy`, `sh_strobe`, `conv_strobe`, `done` and `chan_idx`.
- R2: `trig_sel` enables one hardware source: 1 selects `ext_trig`, 2 selects `mtr_trig` and 3 selects `tmr_trig`. The value 0 and the values 4 to 15 enable none. Requests from sources that are not selected have no effect.
- R3: A start is accepted at the clock edge that first sees either a `sw_start` pulse or a rising edge of the selected source. `start_bit` and `busy` are high from that edge on. The timing that follows is identical for both kinds of start.
- R4: A phase counter is cleared by reset and advances once per clock, modulo 4. Let P be its value after the accepting edge. P equals the number of clock edges since reset release, modulo 4. The start delay is 4 − P clocks when P is nonzero and 4 clocks when P is 0. During the start delay neither strobe is high.
- R5: Each channel gets exactly 6 cycles of `sh_strobe`, followed directly by exactly 16 cycles of `conv_strobe`. The two strobes are never high together.
- R6: In single mode (`mode` = 0, and also the reserved value 3), one channel is converted, and its index is `chan_sel`.
- R7: In multi mode (`mode` = 1), channels 0 to `chan_sel` are converted in ascending order. Each channel after the first starts sampling in the cycle after the previous channel's last convert cycle, with no start delay.
- R8: In single and multi mode, the cycle after the last convert cycle shows `start_bit` and `busy` low and `done` high. `done` is high for exactly one cycle.
- R9: In scan mode (`mode` = 2), the last channel of the group is followed at once by channel 0 with no start delay. `start_bit` stays high and `done` never rises.
- R10: A `sw_stop` pulse clears `start_bit` and `busy` at the next edge, in any state, without a `done` pulse. `sw_stop` takes priority over a start in the same cycle.
- R11: A `sw_start` or a hardware request that arrives while busy is ignored. A hardware request held high starts only one run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sw_start | input | 1 | Software start strobe |
| sw_stop | input | 1 | Software clear of the start bit |
| trig_sel | input | 4 | Hardware trigger source select |
| chan_sel | input | 3 | Channel (single mode) or highest channel of the group |
| mode | input | 2 | 0 single, 1 multi, 2 scan, 3 treated as single |
| ext_trig | input | 1 | External pin request |
| mtr_trig | input | 1 | Motor-control timer request |
| tmr_trig | input | 1 | General timer request |
| start_bit | output | 1 | Conversion start bit |
| busy | output | 1 | Sequence in progress |
| sh_strobe | output | 1 | Sample-and-hold phase |
| conv_strobe | output | 1 | Convert phase |
| done | output | 1 | One-cycle end-of-sequence pulse |
| chan_idx | output | 3 | Channel being sampled or converted |

## Verification
The bench keeps its own count of clock edges since reset release. From that count it predicts the phase at the accepting edge, and from the phase the start delay of 1 to 4 cycles. It then checks every cycle of a run, starting at the accepting edge. Sampling is due exactly after the start delay. Each channel takes 22 cycles, split 6 + 16. `done` is due in the cycle after the last convert cycle. A stop takes effect one cycle after the strobe is seen. All outputs are sampled on the falling edge after the edge that produced them. The bench sweeps every channel setting, every starting phase and every start source in single and multi mode, and covers scan, stop, busy-time and held-request cases.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DLY  = 2'd1,
    ST_SAMP = 2'd2,
    ST_CONV = 2'd3
  } seq_st_e;

  localparam logic [1:0] MD_SINGLE = 2'd0;
  localparam logic [1:0] MD_MULTI  = 2'd1;
  localparam logic [1:0] MD_SCAN   = 2'd2;

  localparam logic [3:0] TS_EXT = 4'd1;
  localparam logic [3:0] TS_MTR = 4'd2;
  localparam logic [3:0] TS_TMR = 4'd3;
endpackage

// File: rtl/adc_phase_gen.sv
module adc_phase_gen #(
  parameter int PH_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic ph_wrap
);
  localparam int PW = (PH_DIV > 1) ? $clog2(PH_DIV) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(PH_DIV - 1);

  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    ph_wrap = (ph_q == PH_LAST);
    ph_d    = ph_wrap ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
#(
  parameter int TS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] trig_sel,
  input  logic            ext_trig,
  input  logic            mtr_trig,
  input  logic            tmr_trig,
  output logic            hw_req
);
  localparam int NSRC = 3;

  logic [NSRC-1:0] src, prev_q, rise;

  assign src  = {tmr_trig, mtr_trig, ext_trig};
  assign rise = src & ~prev_q;

  always_comb begin
    case (trig_sel)
      TS_W'(TS_EXT): hw_req = rise[0];
      TS_W'(TS_MTR): hw_req = rise[1];
      TS_W'(TS_TMR): hw_req = rise[2];
      default:       hw_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src;
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CH_W     = 3,
  parameter int SAMP_CYC = 6,
  parameter int CONV_CYC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_start,
  input  logic            hw_req,
  input  logic            sw_stop,
  input  logic            ph_wrap,
  input  logic [1:0]      mode,
  input  logic [CH_W-1:0] chan_sel,
  output logic            start_bit,
  output logic            busy,
  output logic            sh_strobe,
  output logic            conv_strobe,
  output logic            done,
  output logic [CH_W-1:0] chan_idx
);
  localparam int CNT_MAX = (SAMP_CYC > CONV_CYC) ? SAMP_CYC : CONV_CYC;
  localparam int CW      = $clog2(CNT_MAX);
  localparam logic [CW-1:0] SAMP_LAST = CW'(SAMP_CYC - 1);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYC - 1);

  seq_st_e         st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [CH_W-1:0] ch_q, ch_d, last_q, last_d;
  logic            scan_q, scan_d, start_q, start_d, done_q, done_d;
  logic            start_req, group;

  assign start_req = sw_start | hw_req;
  assign group     = (mode == MD_MULTI) || (mode == MD_SCAN);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    ch_d    = ch_q;
    last_d  = last_q;
    scan_d  = scan_q;
    start_d = start_q;
    done_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_req) begin
          st_d    = ST_DLY;
          start_d = 1'b1;
          cnt_d   = '0;
          scan_d  = (mode == MD_SCAN);
          last_d  = chan_sel;
          ch_d    = group ? '0 : chan_sel;
        end
      end
      ST_DLY: begin
        if (ph_wrap) begin
          st_d  = ST_SAMP;
          cnt_d = '0;
        end
      end
      ST_SAMP: begin
        if (cnt_q == SAMP_LAST) begin
          st_d  = ST_CONV;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CONV: begin
        if (cnt_q == CONV_LAST) begin
          cnt_d = '0;
          if (ch_q != last_q) begin
            ch_d = ch_q + 1'b1;
            st_d = ST_SAMP;
          end else if (scan_q) begin
            ch_d = '0;
            st_d = ST_SAMP;
          end else begin
            st_d    = ST_IDLE;
            start_d = 1'b0;
            done_d  = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (sw_stop) begin
      st_d    = ST_IDLE;
      start_d = 1'b0;
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      ch_q    <= '0;
      last_q  <= '0;
      scan_q  <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      ch_q    <= ch_d;
      last_q  <= last_d;
      scan_q  <= scan_d;
      start_q <= start_d;
      done_q  <= done_d;
    end
  end

  assign start_bit   = start_q;
  assign busy        = (st_q != ST_IDLE);
  assign sh_strobe   = (st_q == ST_SAMP);
  assign conv_strobe = (st_q == ST_CONV);
  assign done        = done_q;
  assign chan_idx    = ch_q;
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int CH_W     = 3,
  parameter int TS_W     = 4,
  parameter int PH_DIV   = 4,
  parameter int SAMP_CYC = 6,
  parameter int CONV_CYC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_start,
  input  logic            sw_stop,
  input  logic [TS_W-1:0] trig_sel,
  input  logic [CH_W-1:0] chan_sel,
  input  logic [1:0]      mode,
  input  logic            ext_trig,
  input  logic            mtr_trig,
  input  logic            tmr_trig,
  output logic            start_bit,
  output logic            busy,
  output logic            sh_strobe,
  output logic            conv_strobe,
  output logic            done,
  output logic [CH_W-1:0] chan_idx
);
  logic ph_wrap, hw_req;

  adc_phase_gen #(.PH_DIV(PH_DIV)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .ph_wrap (ph_wrap)
  );

  adc_trig_sel #(.TS_W(TS_W)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_sel (trig_sel),
    .ext_trig (ext_trig),
    .mtr_trig (mtr_trig),
    .tmr_trig (tmr_trig),
    .hw_req   (hw_req)
  );

  adc_seq_fsm #(
    .CH_W     (CH_W),
    .SAMP_CYC (SAMP_CYC),
    .CONV_CYC (CONV_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_start    (sw_start),
    .hw_req      (hw_req),
    .sw_stop     (sw_stop),
    .ph_wrap     (ph_wrap),
    .mode        (mode),
    .chan_sel    (chan_sel),
    .start_bit   (start_bit),
    .busy        (busy),
    .sh_strobe   (sh_strobe),
    .conv_strobe (conv_strobe),
    .done        (done),
    .chan_idx    (chan_idx)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sw_stop,
  input logic            start_bit,
  input logic            busy,
  input logic            sh_strobe,
  input logic            conv_strobe,
  input logic            done,
  input logic [CH_W-1:0] chan_idx
);
  // R5: sampling and converting never overlap
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sh_strobe && conv_strobe));

  // R5: the end of sampling in a live run hands over to converting
  p_sh_then_conv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sh_strobe) && !sh_strobe && start_bit) |-> conv_strobe);

  // R4: the first cycle after a start is inside the start delay
  p_start_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_bit) |-> (!sh_strobe && !conv_strobe));

  // R8: done lasts one cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done comes with the run closed
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!start_bit && !busy));

  // R10: a stop clears the start bit at the next edge
  p_stop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stop |=> (!start_bit && !busy));

  // R7: the channel does not move during a convert phase
  p_chan_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_strobe && $past(conv_strobe)) |-> $stable(chan_idx));

  // R3: a set start bit always has the sequence running
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_bit |-> busy);
endmodule

bind adc_seq adc_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_stop     (sw_stop),
  .start_bit   (start_bit),
  .busy        (busy),
  .sh_strobe   (sh_strobe),
  .conv_strobe (conv_strobe),
  .done        (done),
  .chan_idx    (chan_idx)
);

// File: tb/adc_seq_tb.sv
`timescale 1ns/1ps
module adc_seq_tb;
  logic       clk;
  logic       rst_n;
  logic       sw_start, sw_stop, ext_trig, mtr_trig, tmr_trig;
  logic [3:0] trig_sel;
  logic [2:0] chan_sel;
  logic [1:0] mode;
  logic       start_bit, busy, sh_strobe, conv_strobe, done;
  logic [2:0] chan_idx;

  int n_edge;
  int vecs;
  int errs;

  adc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .sw_stop(sw_stop),
    .trig_sel(trig_sel), .chan_sel(chan_sel), .mode(mode),
    .ext_trig(ext_trig), .mtr_trig(mtr_trig), .tmr_trig(tmr_trig),
    .start_bit(start_bit), .busy(busy), .sh_strobe(sh_strobe),
    .conv_strobe(conv_strobe), .done(done), .chan_idx(chan_idx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n) n_edge <= n_edge + 1;

  function automatic logic [7:0] outs();
    return {start_bit, busy, sh_strobe, conv_strobe, done, chan_idx};
  endfunction

  task automatic cmp(string req, logic [7:0] act, logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b (start,busy,sh,conv,done,chan) t=%0t",
               req, act, exp, $time);
    end
  endtask

  task automatic drive_req(int src, logic v);
    case (src)
      0: sw_start = v;
      1: ext_trig = v;
      2: mtr_trig = v;
      default: tmr_trig = v;
    endcase
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  // One run checked every cycle from the accepting edge on.
  task automatic run(int src, logic [1:0] md, int csel, int pre,
                     int stop_rel, int inj_k, bit hold, string req);
    int nA, td, nch, first, total, limit, r, j, m;
    logic [7:0] e;
    logic [2:0] cexp;
    trig_sel = (src == 0) ? 4'd0 : 4'(src);
    mode     = md;
    chan_sel = 3'(csel);
    repeat (pre) @(negedge clk);
    nA = n_edge + 1;
    td = 4 - (nA % 4);                       // R4
    drive_req(src, 1'b1);
    @(negedge clk);
    if (!hold) drive_req(src, 1'b0);
    nch   = (md == 2'd1 || md == 2'd2) ? csel + 1 : 1;
    first = (md == 2'd1 || md == 2'd2) ? 0 : csel;
    total = td + nch * 22;
    limit = (stop_rel >= 0) ? td + stop_rel + 1 : total + 1;
    for (int k = 0; k <= limit; k++) begin
      if (stop_rel >= 0 && k == td + stop_rel + 1) begin
        e = {5'b00000, chan_idx};            // R10 stopped, no done
      end else if (k < td) begin
        e = {5'b11000, 3'(first)};           // R3 R4
      end else begin
        r = k - td;
        j = r / 22;
        m = r % 22;
        if (md == 2'd2) j = j % nch;         // R9
        if (j < nch) begin
          cexp = 3'(first + j);              // R6 R7
          e = {1'b1, 1'b1, (m < 6), (m >= 6), 1'b0, cexp};  // R5
        end else if (k == total) begin
          e = {5'b00001, chan_idx};          // R8
        end else begin
          e = {5'b00000, chan_idx};
        end
      end
      cmp(req, outs(), e);
      sw_stop = 1'b0;
      if (stop_rel >= 0 && k == td + stop_rel) sw_stop = 1'b1;
      if (k == inj_k) begin                  // R11 requests while busy
        sw_start = 1'b1; ext_trig = 1'b1; mtr_trig = 1'b1; tmr_trig = 1'b1;
      end else if (k == inj_k + 1) begin
        sw_start = 1'b0; ext_trig = 1'b0; mtr_trig = 1'b0; tmr_trig = 1'b0;
      end
      @(negedge clk);
    end
    sw_stop = 1'b0;
    if (!hold) begin
      sw_start = 1'b0; ext_trig = 1'b0; mtr_trig = 1'b0; tmr_trig = 1'b0;
    end
  endtask

  // A request that must not start anything.
  task automatic no_start(logic [3:0] sel, int src, string req);
    trig_sel = sel;
    mode     = 2'd0;
    @(negedge clk);
    drive_req(src, 1'b1);
    @(negedge clk);
    drive_req(src, 1'b0);
    for (int k = 0; k < 5; k++) begin
      cmp(req, {start_bit, busy, sh_strobe, conv_strobe, done, 3'b000},
          8'b0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    vecs = 0; errs = 0; n_edge = 0;
    rst_n = 1'b0;
    sw_start = 0; sw_stop = 0; ext_trig = 0; mtr_trig = 0; tmr_trig = 0;
    trig_sel = 0; chan_sel = 0; mode = 0;
    repeat (3) @(negedge clk);
    cmp("R1 in reset", outs(), 8'b0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 after reset", outs(), 8'b0);

    // Single and multi over every channel, phase and start source
    for (int md = 0; md < 2; md++)
      for (int cs = 0; cs < 8; cs++)
        for (int pre = 0; pre < 4; pre++)
          run((cs + pre) % 4, 2'(md), cs, pre, -1, -1, 1'b0,
              md == 0 ? "R6 R3 R4 R5 R8 single" : "R7 R3 R4 R5 R8 multi");

    run(0, 2'd3, 5, 1, -1, -1, 1'b0, "R6 reserved mode as single");

    // Scan: two full rounds and part of a third, then stop
    run(1, 2'd2, 1, 0, 100, -1, 1'b0, "R9 R10 scan of two channels");
    run(0, 2'd2, 2, 2, 150, -1, 1'b0, "R9 R10 scan of three channels");
    run(2, 2'd2, 0, 3, 50,  -1, 1'b0, "R9 R10 scan of one channel");

    // Stop in the middle of a multi run
    run(3, 2'd1, 4, 1, 30, -1, 1'b0, "R10 stop during multi");
    run(0, 2'd0, 2, 0, 2,  -1, 1'b0, "R10 stop during sampling");

    // Requests while busy are ignored
    run(1, 2'd1, 2, 0, -1, 12, 1'b0, "R11 requests while busy");
    run(0, 2'd0, 6, 3, -1, 20, 1'b0, "R11 software start while busy");

    // Held request starts only once
    run(2, 2'd0, 3, 2, -1, -1, 1'b1, "R11 held request, run");
    for (int k = 0; k < 10; k++) begin
      cmp("R11 held request stays idle",
          {start_bit, busy, sh_strobe, conv_strobe, done, 3'b000}, 8'b0);
      @(negedge clk);
    end
    mtr_trig = 1'b0;
    @(negedge clk);

    // Sources not selected
    no_start(4'd1, 2, "R2 motor request with external selected");
    no_start(4'd2, 3, "R2 timer request with motor selected");
    no_start(4'd3, 1, "R2 external request with timer selected");
    for (int s = 0; s < 16; s++)
      if (s == 0 || s > 3) begin
        no_start(4'(s), 1, "R2 external with no source enabled");
        no_start(4'(s), 2, "R2 motor with no source enabled");
        no_start(4'(s), 3, "R2 timer with no source enabled");
      end

    // Stop and start in the same cycle: stop wins
    trig_sel = 4'd0;
    @(negedge clk);
    sw_start = 1'b1; sw_stop = 1'b1;
    @(negedge clk);
    sw_start = 1'b0; sw_stop = 1'b0;
    cmp("R10 stop beats start", outs() & 8'hF8, 8'b0);

    finish_run();
  end
endmodule